// File: doc/BRIEF.md
# Phase Lock Detector

This block decides whether a digital phase-locked loop has locked. It watches a two's-complement phase-error word from the phase detector: the difference between the input reference and the fed-back output clock. Each valid sample's magnitude is compared against a programmable bound. Time is cut into 4 ms monitoring windows, each closed by a tick from a shared timebase. A window is clean when none of its valid samples reached the bound.

Lock is declared only after a programmable number of consecutive clean windows. Once declared, it holds until a window closes dirty. Any change of the lock status also raises a one-cycle change pulse, so a status register or an interrupt collector can capture the event without polling.

Top module: `phase_lock_det`

## Requirements
- R1: While reset is active, and after reset is released, `lock_o` and `lock_chg_o` are 0 and no clean windows are counted. Reset takes hold at once and is released two clock edges after `rst_n` rises.
- R2: A valid sample violates when the absolute value of `err_word` is greater than or equal to `thr_cfg`. `err_word` is read as two's complement, so the most negative value has magnitude 2^(ERR_W-1); `thr_cfg` is unsigned. A threshold of 0 makes every valid sample violate.
- R3: A sample with `err_valid` low has no effect on the window, whatever its value.
- R4: A window closes on the cycle where `win_tick` is high, and a sample presented in that same cycle belongs to the closing window. A window with any violation clears the clean-window count and drives `lock_o` to 0 on the clock edge after the tick.
- R5: `lock_o` rises on the edge after the tick that closes the N-th consecutive clean window, where N is `intv_cfg`. An `intv_cfg` of 0 acts as 1.
- R6: Once locked, every further clean window keeps `lock_o` at 1.
- R7: `lock_chg_o` is 1 for exactly the cycle in which `lock_o` has just changed, and 0 otherwise.
- R8: `lock_o` changes only on the edge after a tick. A violation in the middle of a window leaves lock unchanged until that window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | Phase-error sample strobe |
| err_word | input | ERR_W | Signed phase error from the phase detector |
| win_tick | input | 1 | One-cycle pulse closing a 4 ms window |
| thr_cfg | input | ERR_W | Unsigned magnitude bound |
| intv_cfg | input | INT_W | Clean windows needed for lock |
| lock_o | output | 1 | Lock status |
| lock_chg_o | output | 1 | One-cycle pulse on each lock change |

## Verification
A stuck window-dirty flag shows at the ports within one window. Lock either falls on a clean window or fails to fall on a dirty one, and this is visible the cycle after the next tick. A clean-window count that fails to clear, or that counts wrongly, shifts the rise of `lock_o` by whole windows. The bench therefore checks lock on the exact cycle after every tick, across threshold equality, the most negative error, a zero interval and a zero threshold. A stale change pulse is caught one cycle after any lock edge.

// File: rtl/plock_pkg.sv
`timescale 1ns/1ps
package plock_pkg;
  typedef enum logic {
    ST_UNLOCKED = 1'b0,
    ST_LOCKED   = 1'b1
  } lock_state_e;

  // Result of one monitoring window, valid while close is high
  typedef struct packed {
    logic close;
    logic dirty;
  } win_result_t;
endpackage

// File: rtl/plock_mag_cmp.sv
`timescale 1ns/1ps
module plock_mag_cmp #(
  parameter int ERR_W = 16
) (
  input  logic [ERR_W-1:0] err_i,
  input  logic [ERR_W-1:0] thr_i,
  output logic             viol_o
);
  logic [ERR_W-1:0] mag;

  // Absolute value; the most negative input maps to 2^(ERR_W-1) unsigned
  always_comb begin
    if (err_i[ERR_W-1]) mag = (~err_i) + ERR_W'(1);
    else                mag = err_i;
    viol_o = (mag >= thr_i);
  end
endmodule

// File: rtl/plock_window.sv
`timescale 1ns/1ps
module plock_window
  import plock_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_i,
  input  logic        viol_i,
  input  logic        tick_i,
  output win_result_t result_o
);
  logic dirty_q, dirty_d, hit;

  always_comb begin
    hit            = valid_i & viol_i;
    result_o.close = tick_i;
    result_o.dirty = dirty_q | hit;
    dirty_d        = tick_i ? 1'b0 : (dirty_q | hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dirty_q <= 1'b0;
    else        dirty_q <= dirty_d;
  end

  // R4: a dirty mark survives until the window closes
  p_dirty_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_q && !tick_i) |=> dirty_q);
endmodule

// File: rtl/plock_lock_fsm.sv
`timescale 1ns/1ps
module plock_lock_fsm
  import plock_pkg::*;
#(
  parameter int INT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  win_result_t      res_i,
  input  logic [INT_W-1:0] intv_i,
  output logic             lock_o,
  output logic             chg_o
);
  localparam logic [INT_W-1:0] CNT_MAX = '1;

  lock_state_e      state_q, state_d;
  logic [INT_W-1:0] cnt_q, cnt_d, cnt_inc, need;
  logic             chg_q, chg_d;

  always_comb begin
    need    = (intv_i == '0) ? INT_W'(1) : intv_i;
    cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + INT_W'(1);
    cnt_d   = cnt_q;
    state_d = state_q;
    if (res_i.close) begin
      if (res_i.dirty) begin
        cnt_d   = '0;
        state_d = ST_UNLOCKED;
      end else begin
        cnt_d = cnt_inc;
        if (cnt_inc >= need) state_d = ST_LOCKED;
      end
    end
    chg_d = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_UNLOCKED;
      cnt_q   <= '0;
      chg_q   <= 1'b0;
    end else begin
      chg_q <= chg_d;
      if (res_i.close) begin
        state_q <= state_d;
        cnt_q   <= cnt_d;
      end
    end
  end

  assign lock_o = (state_q == ST_LOCKED);
  assign chg_o  = chg_q;

  // R4: a dirty window clears the count and lock
  p_dirty_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_i.close && res_i.dirty) |=> (cnt_q == '0 && !lock_o));
  // R8: lock moves only after a window close
  p_hold_between_ticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_i.close |=> $stable(state_q));
  // R6: a clean close never removes lock
  p_clean_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_i.close && !res_i.dirty && lock_o) |=> lock_o);
endmodule

// File: rtl/phase_lock_det.sv
`timescale 1ns/1ps
module phase_lock_det
  import plock_pkg::*;
#(
  parameter int ERR_W = 16,
  parameter int INT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_valid,
  input  logic [ERR_W-1:0] err_word,
  input  logic             win_tick,
  input  logic [ERR_W-1:0] thr_cfg,
  input  logic [INT_W-1:0] intv_cfg,
  output logic             lock_o,
  output logic             lock_chg_o
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;
  logic              viol;
  win_result_t       win_res;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  plock_mag_cmp #(.ERR_W(ERR_W)) u_cmp (
    .err_i  (err_word),
    .thr_i  (thr_cfg),
    .viol_o (viol)
  );

  plock_window u_win (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .valid_i  (err_valid),
    .viol_i   (viol),
    .tick_i   (win_tick),
    .result_o (win_res)
  );

  plock_lock_fsm #(.INT_W(INT_W)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .res_i  (win_res),
    .intv_i (intv_cfg),
    .lock_o (lock_o),
    .chg_o  (lock_chg_o)
  );

  // R7: the pulse marks exactly the cycles where lock has just moved
  p_chg_pulse_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    lock_chg_o |-> (lock_o != $past(lock_o)));
  p_chg_needed_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lock_o != $past(lock_o)) |-> lock_chg_o);
  // R2: a zero bound flags every valid sample
  p_zero_thr_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (thr_cfg == '0) |-> viol);
  // R1: nothing is held while reset is in force
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |-> (!lock_o && !lock_chg_o));
endmodule

// File: tb/phase_lock_det_tb_top.sv
`timescale 1ns/1ps
module phase_lock_det_tb_top;
  localparam int ERR_W = 16;
  localparam int INT_W = 8;
  localparam int NVEC  = 12;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             err_valid;
  logic [ERR_W-1:0] err_word;
  logic             win_tick;
  logic [ERR_W-1:0] thr_cfg;
  logic [INT_W-1:0] intv_cfg;
  logic             lock_o, lock_chg_o;

  int n_chk = 0, n_fail = 0;
  logic exp_prev = 1'b0;

  // {error sample, expected lock} per window; bound 100, interval 3
  localparam logic [ERR_W:0] VEC [NVEC] = '{
    {16'sd10,    1'b0}, {16'sd20,    1'b0}, {-16'sd50,  1'b1},
    {16'sd99,    1'b1}, {-16'sd99,   1'b1}, {16'sd100,  1'b0},
    {16'sd5,     1'b0}, {-16'sd100,  1'b0}, {16'sd7,    1'b0},
    {-16'sd8,    1'b0}, {16'sd9,     1'b1}, {16'h8000,  1'b0}
  };

  always #2 clk = ~clk;

  phase_lock_det #(.ERR_W(ERR_W), .INT_W(INT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_word(err_word),
    .win_tick(win_tick), .thr_cfg(thr_cfg), .intv_cfg(intv_cfg),
    .lock_o(lock_o), .lock_chg_o(lock_chg_o)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // One window: an optional mid-window sample, then the closing tick.
  // Lock and the change pulse are checked in the cycle after the tick.
  task automatic window(input string tag, input logic [ERR_W-1:0] e,
                        input logic vld, input logic on_tick, input logic exp);
    if (!on_tick) begin
      err_valid = vld; err_word = e;
      @(negedge clk);
      err_valid = 1'b0;
      check({tag, " lock mid-window"}, lock_o, exp_prev);
    end else begin
      err_valid = vld; err_word = e;
    end
    win_tick = 1'b1;
    @(negedge clk);
    win_tick = 1'b0; err_valid = 1'b0;
    check({tag, " lock"}, lock_o, exp);
    check({tag, " change pulse"}, lock_chg_o, exp != exp_prev);
    exp_prev = exp;
    @(negedge clk);
    check({tag, " pulse ends"}, lock_chg_o, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_prev = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    err_valid = 1'b0; err_word = '0; win_tick = 1'b0;
    thr_cfg = 16'd100; intv_cfg = 8'd3;
    @(negedge clk);
    do_reset();
    check("R1 lock after reset", lock_o, 1'b0);
    check("R1 pulse after reset", lock_chg_o, 1'b0);

    // Table walk: R2 equality and negatives, R4 drop, R5 count of 3, R6 hold
    for (int i = 0; i < NVEC; i++)
      window($sformatf("R5/R4/R2 vec %0d", i), VEC[i][ERR_W:1], 1'b1, 1'b0, VEC[i][0]);

    // R5: an interval of 0 acts as 1
    intv_cfg = 8'd0;
    window("R5 zero interval", 16'sd1, 1'b1, 1'b0, 1'b1);
    // R3: an unstrobed huge error is ignored
    window("R3 invalid sample", 16'sd30000, 1'b0, 1'b0, 1'b1);
    // R6: repeated clean windows hold lock
    intv_cfg = 8'd1;
    for (int k = 0; k < 5; k++) window("R6 hold", 16'sd3, 1'b1, 1'b0, 1'b1);
    // R8: a mid-window violation waits for the tick
    window("R8 deferred drop", 16'sd500, 1'b1, 1'b0, 1'b0);
    window("R5 relock", 16'sd2, 1'b1, 1'b0, 1'b1);
    // R4: a violation in the tick cycle belongs to the closing window
    window("R4 tick-cycle sample", -16'sd200, 1'b1, 1'b1, 1'b0);
    // R2: the most negative magnitude against a bound of 2^15
    thr_cfg = 16'h8000;
    window("R2 below 2^15", 16'sd32767, 1'b1, 1'b0, 1'b1);
    window("R2 most negative", 16'h8000, 1'b1, 1'b0, 1'b0);
    // R2: a zero bound flags a zero error
    thr_cfg = 16'd100;
    window("R2 relock", 16'sd0, 1'b1, 1'b0, 1'b1);
    thr_cfg = 16'd0;
    window("R2 zero bound", 16'sd0, 1'b1, 1'b0, 1'b0);
    // R1: reset while locked clears at once
    thr_cfg = 16'd100;
    window("R1 relock", 16'sd4, 1'b1, 1'b0, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R1 async clear lock", lock_o, 1'b0);
    check("R1 async clear pulse", lock_chg_o, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_prev = 1'b0;
    check("R1 lock after release", lock_o, 1'b0);
    intv_cfg = 8'd2;
    window("R1 count restarted", 16'sd1, 1'b1, 1'b0, 1'b0);
    window("R1 second window", 16'sd1, 1'b1, 1'b0, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule